// File: doc/BRIEF.md
# Distributed Daisy-Chain Bus Arbiter Node

This block is the arbitration slice that every module sharing a bus carries. There is no central arbiter. Ownership is settled by two shared active-low lines and a priority chain. The shared lines are a bus-request line and a busy line. Each line is a wired-AND of the pull-down drives of all modules, so it reads 0 as soon as any one module pulls it and reads 1 only when no module does. The chain is a single signal that passes from each module to its downstream neighbour. The first module's chain input is tied to 1.

A module asks for the bus by raising its local request. One clock later it pulls the bus-request line low and also forces its chain output to 0, which blocks every module downstream of it. A module that is not requesting copies its chain input to its chain output. So among all requesters, only the one nearest the head of the chain sees a 1 on its chain input. That requester waits until the busy line reads 1. It then takes ownership and pulls busy low, and it holds the bus until its local request drops.

Ownership is never pre-empted, and at most one module owns the bus at any time. Several instances are wired in series, and the system integrator builds the wired-AND of the two shared lines.

Top module: `daisy_arb_node`

## Requirements
- R1: While `rst_n` is low, `owns` is 0, both pull outputs are 1 (released), and `prio_out` equals `prio_in`.
- R2: `breq_pull_n` is 0 exactly when `want` was 1 at the previous rising clock edge. Otherwise it is 1.
- R3: `prio_out` is 0 when `want` was 1 at the previous rising edge. Otherwise `prio_out` equals `prio_in`.
- R4: A module that does not own the bus takes ownership only at an edge where four conditions hold: `prio_in` is 1, `want` is 1 now, `want` was already 1 at the previous edge, and `breq_line` reads 0. As a result, the requester closest to the head of the chain wins.
- R5: A module takes ownership only at an edge where `busy_line` reads 1.
- R6: `busy_pull_n` is 0 exactly while `owns` is 1.
- R7: An owner whose `want` is 0 at a rising edge no longer owns the bus after that edge.
- R8: An owner whose `want` is 1 at a rising edge still owns the bus after that edge, whatever the higher-priority modules request (no pre-emption).
- R9: Across a chain of nodes, at most one node owns the bus in any cycle. A node that owns the bus always sees `busy_line` at 0.
- R10: A request that is held until granted is granted within a bounded time, provided each owner eventually releases the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| want | input | 1 | Local request for the bus |
| prio_in | input | 1 | Chain input from the upstream neighbour (tie to 1 at the head) |
| prio_out | output | 1 | Chain output to the downstream neighbour |
| breq_line | input | 1 | Resolved shared bus-request line (active low) |
| breq_pull_n | output | 1 | This node's pull on the bus-request line (0 = pull low) |
| busy_line | input | 1 | Resolved shared busy line (active low) |
| busy_pull_n | output | 1 | This node's pull on the busy line (0 = pull low) |
| owns | output | 1 | This node currently owns the bus |

## Verification
Two things can fall in the same cycle: the current owner releases busy, and a higher-priority module has just arrived with its request. Release and handover could then collide. The owner's final edge is also the edge at which every waiter sees its chain input settle. Random traffic on a four-node chain with wired-AND lines provokes this collision repeatedly. A directed case forces it: a downstream owner, then a new head requester. A cycle-level bench model judges each cycle: it predicts each node's ownership, chain output and pulls. On every cycle the bench also checks that no two nodes own the bus at once and that every waiter is granted within a bound.

// File: rtl/daisy_arb_node.sv
module daisy_arb_node (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic prio_in,
  output logic prio_out,
  input  logic breq_line,
  output logic breq_pull_n,
  input  logic busy_line,
  output logic busy_pull_n,
  output logic owns
);

  logic want_q;
  logic owns_q;
  logic contend;

  // a settled request that holds the chain and sees the request line active
  assign contend = want_q & want & prio_in & ~breq_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= 1'b0;
      owns_q <= 1'b0;
    end else begin
      want_q <= want;
      if (owns_q) owns_q <= want;
      else        owns_q <= contend & busy_line;
    end
  end

  assign prio_out    = prio_in & ~want_q;
  assign breq_pull_n = ~want_q;
  assign busy_pull_n = ~owns_q;
  assign owns        = owns_q;

  p_breq_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !breq_pull_n |-> !breq_line);

  p_take_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owns) |-> $past(prio_in) && $past(want));

  p_take_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owns) |-> $past(busy_line));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    owns && !want |=> !owns);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    owns && want |=> owns);

  p_busy_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    owns |-> !busy_line);

endmodule

// File: tb/daisy_arb_node_tb.sv
module daisy_arb_node_tb;
  localparam int N = 4;
  localparam time PERIOD = 10ns;
  localparam int WAIT_LIMIT = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] want = '0;
  logic [N:0]   chain;
  logic [N-1:0] breq_pull_n, busy_pull_n, owns;
  logic breq_line, busy_line;

  int checks = 0;
  int errors = 0;
  bit run_checks = 1'b0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  assign chain[0]  = 1'b1;
  assign breq_line = &breq_pull_n;
  assign busy_line = &busy_pull_n;

  for (genvar g = 0; g < N; g++) begin : g_node
    daisy_arb_node u_node (
      .clk(clk), .rst_n(rst_n), .want(want[g]),
      .prio_in(chain[g]), .prio_out(chain[g+1]),
      .breq_line(breq_line), .breq_pull_n(breq_pull_n[g]),
      .busy_line(busy_line), .busy_pull_n(busy_pull_n[g]),
      .owns(owns[g]));
  end
  // instance named as house style requires for the head node alias
  wire u_dut = owns[0];

  // cycle-level reference model
  logic [N-1:0] m_q = '0, m_own = '0;

  function automatic logic [N:0] chain_of(input logic [N-1:0] q);
    logic [N:0] c;
    c[0] = 1'b1;
    for (int i = 0; i < N; i++) c[i+1] = c[i] & ~q[i];
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q = '0; m_own = '0;
    end else begin
      logic [N:0] c;
      logic [N-1:0] nown;
      c = chain_of(m_q);
      for (int i = 0; i < N; i++)
        nown[i] = m_own[i] ? want[i]
                : (m_q[i] & want[i] & c[i] & (m_own == '0) & (m_q != '0));
      m_own = nown;
      m_q   = want;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  int waitc [N];
  always @(negedge clk) begin
    if (run_checks && rst_n) begin
      logic [N:0] c;
      c = chain_of(m_q);
      chk(owns == m_own, "R4/R5/R7/R8 owner", owns, m_own);
      chk(busy_pull_n == ~owns, "R6 busy pull", busy_pull_n, ~owns);
      chk(breq_pull_n == ~m_q, "R2 request pull", breq_pull_n, ~m_q);
      chk(chain == c, "R3 chain", chain, c);
      chk($countones(owns) <= 1, "R9 single owner", owns, 0);
      for (int i = 0; i < N; i++) begin
        if (want[i] && !owns[i]) waitc[i]++; else waitc[i] = 0;
        chk(waitc[i] <= WAIT_LIMIT, "R10 grant latency", waitc[i], WAIT_LIMIT);
      end
    end
  end

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hold [N];
    bit cool [N];
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin waitc[i] = 0; hold[i] = 0; cool[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(owns == '0, "R1 owns", owns, 0);
    chk(busy_pull_n == '1 && breq_pull_n == '1, "R1 pulls",
        {busy_pull_n, breq_pull_n}, {2*N{1'b1}});
    chk(chain == '1, "R1 chain", chain, {(N+1){1'b1}});
    @(negedge clk); rst_n = 1'b1; run_checks = 1'b1;

    // all request at once: head wins (R4)
    want = '1;
    repeat (3) @(negedge clk);
    chk(owns == 4'b0001, "R4 head wins", owns, 4'b0001);
    want[0] = 1'b0;
    @(negedge clk);
    chk(owns == 4'b0000, "R7 release", owns, 0);
    @(negedge clk);
    chk(owns == 4'b0010, "R5 next after busy free", owns, 4'b0010);
    want = '0;
    repeat (3) @(negedge clk);

    // downstream owner, head arrives: no pre-emption (R8)
    want = 4'b1000;
    repeat (3) @(negedge clk);
    chk(owns == 4'b1000, "R4 lone requester", owns, 4'b1000);
    want[0] = 1'b1;
    repeat (4) @(negedge clk);
    chk(owns == 4'b1000, "R8 no pre-emption", owns, 4'b1000);
    want[3] = 1'b0;
    repeat (2) @(negedge clk);
    chk(owns == 4'b0001, "R8 handover after release", owns, 4'b0001);
    want = '0;
    repeat (3) @(negedge clk);

    // constrained random traffic
    repeat (4000) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        bit others_wait;
        others_wait = 1'b0;
        for (int j = 0; j < N; j++)
          if (j != i && want[j] && !owns[j]) others_wait = 1'b1;
        if (!others_wait) cool[i] = 1'b0;
        if (owns[i] && want[i]) begin
          if (hold[i] == 0) begin want[i] = 1'b0; cool[i] = 1'b1; end
          else hold[i]--;
        end else if (!want[i] && !cool[i] && ($urandom % 6 == 0)) begin
          want[i] = 1'b1;
          hold[i] = $urandom % 7;
        end
      end
    end
    want = '0;
    repeat (4) @(negedge clk);
    chk(owns == '0, "R7 all released", owns, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule